// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block moves one 8-bit time slot on a PCM highway. A frame sync and a serial bit clock come in from the highway, and the block derives from them the edges on which it sends one byte, most significant bit first, and on which it samples one byte from the receive line. A single configuration byte selects the timing. It sets one or two clock periods per data bit, which clock edge launches transmit bits, and which clock edge samples receive bits. It also sets the slot start as zero to seven data periods after the frame sync, whether the last transmit bit is driven for only half a period, and whether the access edges move one clock later in two-clocks-per-bit mode.

The block runs on a fast system clock. The bit clock, frame sync and receive data are sampled as data on that clock, so every highway edge becomes a one-cycle event inside the block. The transmit byte is captured when the first slot bit is launched. The received byte appears on a parallel output together with a one-cycle strobe. A configuration write is held and takes effect at the next frame start, so a slot already in progress keeps its timing.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset the configuration is 00h, `txOe` and `rxValid` are low, and nothing is driven until the first frame start.
- R2: A frame starts at a bit-clock rising edge that samples `fsc` high when the previous rising edge sampled it low. That rising edge is clock 0. Configuration bits [2:0] delay the slot by that many data periods.
- R3: With bit 7 = 0 each slot bit lasts one bit-clock period. Bits go out MSB first, and `txByte` is captured when the first slot bit is launched.
- R4: With bit 7 = 1 each slot bit lasts two bit-clock periods, and the offset counts in these two-clock periods.
- R5: Bit 6 selects the launch edge for transmit bits: 0 launches on the rising edge of a bit's first clock, and 1 launches on the falling edge that follows it.
- R6: Bit 5 selects the receive sample edge: 0 samples on the falling edge inside the bit's last clock, and 1 samples on the rising edge that ends that clock.
- R7: With bit 4 = 1 in one-clock mode, the last slot bit is driven for only half a clock and `txOe` then drops. In two-clock mode bit 4 has no effect.
- R8: With bit 3 = 1 in two-clock mode, both the transmit and receive edges move one bit-clock later. In one-clock mode bit 3 has no effect.
- R9: `txOe` is high exactly while slot bits are being driven and low at all other times.
- R10: After the last slot bit is sampled, `rxValid` pulses for one system cycle, with the assembled byte on `rxByte`.
- R11: A configuration write takes effect only at the next frame start and does not change the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pcmClk | input | 1 | Highway bit clock, sampled on clk |
| fsc | input | 1 | Frame sync, sampled on bit-clock rising edges |
| rxData | input | 1 | Serial receive data |
| txByte | input | 8 | Byte to send in the slot |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 8 | Configuration byte to write |
| txData | output | 1 | Serial transmit data |
| txOe | output | 1 | Transmit output enable |
| rxByte | output | 8 | Received slot byte |
| rxValid | output | 1 | One-cycle strobe for rxByte |

## Verification
The assertions assume that `pcmClk`, `fsc` and `rxData` change in step with the system clock, and that each bit-clock half period lasts at least two system cycles. Under these conditions highway edges never fall in adjacent cycles. They also assume that frame syncs are spaced beyond the end of the slot. The bench drives every highway signal on the falling system-clock edge and holds each bit-clock half for four cycles. It changes receive data only in the middle of a half period, and it leaves idle bit-clock periods between frames, so these assumptions always hold.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int SLOT_BITS = 8;
  localparam int OFF_W     = 3;
  localparam int CNT_W     = 6;

  // Field order follows the configuration byte, bit 7 down to bit 0
  typedef struct packed {
    logic             dbl;       // two clocks per bit
    logic             txFall;    // launch on falling edge
    logic             rxRise;    // sample on rising edge
    logic             halfLast;  // last bit driven half period
    logic             lateEdge;  // edges one clock later (double mode)
    logic [OFF_W-1:0] offset;    // slot delay in data periods
  } slotCfg_t;

  typedef struct packed {
    logic load;  // launch first slot bit, capture tx byte
    logic step;  // launch next slot bit
    logic drop;  // release the line
    logic take;  // sample one receive bit
    logic done;  // the sample just taken is the last one
  } slotStrb_t;
endpackage

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_slot_pkg::*;
#(
  parameter int CW    = CNT_W,
  parameter int SBITS = SLOT_BITS
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pcmClk,
  input  logic      fsc,
  input  logic      cfgWe,
  input  slotCfg_t  cfgData,
  output slotStrb_t strb
);
  localparam logic [CW-1:0] IDX_MAX  = '1;
  localparam logic [CW-1:0] SLOT_LEN = CW'(SBITS);
  localparam logic [CW-1:0] LAST_POS = CW'(SBITS - 1);

  logic          clkQ, fscSeen;
  logic          riseEv, fallEv, frameStart;
  slotCfg_t      cfgReg, activeCfg, eff;
  logic [CW-1:0] clkIdx, cur, base;
  logic [CW-1:0] txRel, txPos, rxLo, rxRel, rxPos;
  logic          lateOn, halfOn, txEv, rxEv, txGo, rxGo, halfDrop;

  always_comb begin
    riseEv     = pcmClk & ~clkQ;
    fallEv     = ~pcmClk & clkQ;
    frameStart = riseEv & fsc & ~fscSeen;
    eff        = frameStart ? cfgReg : activeCfg;
    lateOn     = eff.lateEdge & eff.dbl;
    halfOn     = eff.halfLast & ~eff.dbl;
    base       = (CW'(eff.offset) << eff.dbl) + CW'(lateOn);

    if (frameStart)             cur = '0;
    else if (!riseEv)           cur = clkIdx;
    else if (clkIdx == IDX_MAX) cur = IDX_MAX;
    else                        cur = clkIdx + 1'b1;

    txEv  = eff.txFall ? fallEv : riseEv;
    txRel = cur - base;
    txPos = eff.dbl ? (txRel >> 1) : txRel;
    txGo  = txEv && (cur >= base) && (!eff.dbl || !txRel[0]);

    if (eff.txFall) halfDrop = halfOn && riseEv && (cur == base + SLOT_LEN);
    else            halfDrop = halfOn && fallEv && (cur == base + LAST_POS);

    rxEv  = eff.rxRise ? riseEv : fallEv;
    rxLo  = base + CW'(eff.dbl) + CW'(eff.rxRise);
    rxRel = cur - rxLo;
    rxPos = eff.dbl ? (rxRel >> 1) : rxRel;
    rxGo  = rxEv && (cur >= rxLo) && (!eff.dbl || !rxRel[0]);

    strb.load = txGo && (txPos == '0);
    strb.step = txGo && (txPos != '0) && (txPos < SLOT_LEN);
    strb.drop = (txGo && (txPos == SLOT_LEN)) || halfDrop;
    strb.take = rxGo && (rxPos < SLOT_LEN);
    strb.done = rxGo && (rxPos == LAST_POS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkQ      <= 1'b0;
      fscSeen   <= 1'b0;
      clkIdx    <= IDX_MAX;
      cfgReg    <= '0;
      activeCfg <= '0;
    end else begin
      clkQ   <= pcmClk;
      clkIdx <= cur;
      if (riseEv)     fscSeen   <= fsc;
      if (cfgWe)      cfgReg    <= cfgData;
      if (frameStart) activeCfg <= cfgReg;
    end
  end

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> (activeCfg == $past(activeCfg)));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.step, strb.drop}));

  // R10
  done_with_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |-> strb.take);
endmodule

// File: rtl/pcm_slot_dp.sv
module pcm_slot_dp
  import pcm_slot_pkg::*;
#(
  parameter int SBITS = SLOT_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotStrb_t        strb,
  input  logic [SBITS-1:0] txByte,
  input  logic             rxData,
  output logic             txData,
  output logic             txOe,
  output logic [SBITS-1:0] rxByte,
  output logic             rxValid
);
  logic [SBITS-1:0] txSh, rxSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh    <= '0;
      txData  <= 1'b0;
      txOe    <= 1'b0;
      rxSh    <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (strb.load) begin
        txData <= txByte[SBITS-1];
        txSh   <= {txByte[SBITS-2:0], 1'b0};
        txOe   <= 1'b1;
      end else if (strb.step) begin
        txData <= txSh[SBITS-1];
        txSh   <= {txSh[SBITS-2:0], 1'b0};
      end
      if (strb.drop) txOe <= 1'b0;
      if (strb.take) rxSh <= {rxSh[SBITS-2:0], rxData};
      if (strb.done) rxByte <= {rxSh[SBITS-2:0], rxData};
      rxValid <= strb.done;
    end
  end

  // R9
  oe_rise_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOe) |-> $past(strb.load));

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(txData));

  // R10
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pcmClk,
  input  logic       fsc,
  input  logic       rxData,
  input  logic [7:0] txByte,
  input  logic       cfgWe,
  input  logic [7:0] cfgData,
  output logic       txData,
  output logic       txOe,
  output logic [7:0] rxByte,
  output logic       rxValid
);
  slotStrb_t strb;
  slotCfg_t  cfgIn;

  assign cfgIn = slotCfg_t'(cfgData);

  pcm_slot_ctrl #(.CW(CNT_W), .SBITS(SLOT_BITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pcmClk  (pcmClk),
    .fsc     (fsc),
    .cfgWe   (cfgWe),
    .cfgData (cfgIn),
    .strb    (strb)
  );

  pcm_slot_dp #(.SBITS(SLOT_BITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txByte  (txByte),
    .rxData  (rxData),
    .txData  (txData),
    .txOe    (txOe),
    .rxByte  (rxByte),
    .rxValid (rxValid)
  );
endmodule

// File: tb/pcm_slot_port_bench.sv
module pcm_slot_port_bench;
  logic       clk = 1'b0, rstN = 1'b0, pcmClk = 1'b0, fsc = 1'b0, rxData = 1'b0, cfgWe = 1'b0;
  logic [7:0] txByte = '0, cfgData = '0;
  logic       txData, txOe, rxValid;
  logic [7:0] rxByte;

  int        nChecks = 0, nFails = 0;
  bit        finished = 0;
  logic [7:0] rxQ[$];
  string     curReq = "R6";

  always #5 clk = ~clk;

  pcm_slot_port u_pcm_slot_port (
    .clk(clk), .rstN(rstN), .pcmClk(pcmClk), .fsc(fsc), .rxData(rxData),
    .txByte(txByte), .cfgWe(cfgWe), .cfgData(cfgData),
    .txData(txData), .txOe(txOe), .rxByte(rxByte), .rxValid(rxValid)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected receive bytes as the design presents them (R10)
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      if (rxQ.size() == 0) check(1'b0, "R10", "unexpected rxValid", rxByte, 0);
      else begin
        logic [7:0] exp;
        exp = rxQ.pop_front();
        check(rxByte == exp, curReq, "rx byte", rxByte, exp);
      end
    end
  end

  // One bit-clock half period: four system cycles
  task automatic halfStep(input int h, input bit rxBit, input bit fscVal, input bit expOe,
                          input bit expDat, input string req, input bit midWr, input logic [7:0] midCfg);
    @(negedge clk) pcmClk = ((h & 1) == 0);
    @(negedge clk) if (midWr) begin cfgWe = 1'b1; cfgData = midCfg; end
    @(negedge clk) begin cfgWe = 1'b0; rxData = rxBit; fsc = fscVal; end
    @(negedge clk) begin
      check(txOe == expOe, req, $sformatf("txOe half %0d", h), txOe, expOe);
      if (expOe) check(txData == expDat, req, $sformatf("txData half %0d", h), txData, expDat);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) halfStep(i, 1'($urandom), 1'b0, 1'b0, 1'b0, "R9", 1'b0, 8'h00);
  endtask

  task automatic writeCfg(input logic [7:0] c);
    @(negedge clk) begin cfgWe = 1'b1; cfgData = c; end
    @(negedge clk) cfgWe = 1'b0;
  endtask

  // Driver: pushes the expected receive byte, drives one frame, checks tx per half
  task automatic runFrame(input logic [7:0] cfg, input logic [7:0] tx, input logic [7:0] rx,
                          input string req, input bit midWr = 1'b0, input logic [7:0] midCfg = 8'h00);
    int w, base, ts, rs, firstHalf;
    bit halfOn;
    w      = cfg[7] ? 2 : 1;
    halfOn = cfg[4] && !cfg[7];
    base   = w * int'(cfg[2:0]) + ((cfg[7] && cfg[3]) ? 1 : 0);
    ts     = int'(cfg[6]);
    rs     = int'(cfg[5]);
    firstHalf = 2 * base + ts;
    curReq = req;
    rxQ.push_back(rx);
    txByte = tx;
    for (int h = -4; h < 68; h++) begin
      bit eo, ed, rb;
      eo = 1'b0; ed = 1'b0; rb = 1'($urandom);
      for (int k = 0; k < 8; k++) begin
        int st, len, hs;
        st  = 2 * (base + w * k) + ts;
        len = (k == 7 && halfOn) ? 1 : 2 * w;
        hs  = 2 * (base + w * k + w - 1) + rs;
        if (h >= st && h < st + len) begin eo = 1'b1; ed = tx[7-k]; end
        if (h == hs) rb = rx[7-k];
      end
      if (h == firstHalf + 1) txByte = ~tx;  // captured already (R3)
      halfStep(h, rb, (h >= -1 && h <= 1), eo, ed, req, midWr && (h == 10), midCfg);
    end
    check(rxQ.size() == 0, "R10", "one rxValid per frame", rxQ.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(txOe == 1'b0, "R1", "txOe in reset", txOe, 0);
    check(rxValid == 1'b0, "R1", "rxValid in reset", rxValid, 0);
    @(negedge clk) rstN = 1'b1;
    idle(8);                                         // R1: no frame yet, nothing driven
    runFrame(8'h00, 8'hA5, 8'h3C, "R1");             // default config after reset
    idle(4);
    writeCfg(8'h03); runFrame(8'h03, 8'h5A, 8'hC3, "R2");
    idle(4);
    writeCfg(8'h07); runFrame(8'h07, 8'hFF, 8'h00, "R2");
    idle(4);
    writeCfg(8'h00); runFrame(8'h00, 8'h00, 8'hFF, "R3");
    idle(4);
    writeCfg(8'h80); runFrame(8'h80, 8'h96, 8'h69, "R4");
    idle(4);
    writeCfg(8'h82); runFrame(8'h82, 8'h1E, 8'hE1, "R4");
    idle(4);
    writeCfg(8'h40); runFrame(8'h40, 8'hC5, 8'h5C, "R5");
    idle(4);
    writeCfg(8'h20); runFrame(8'h20, 8'h33, 8'hB4, "R6");
    idle(4);
    writeCfg(8'h10); runFrame(8'h10, 8'h81, 8'h7E, "R7");
    idle(4);
    writeCfg(8'h51); runFrame(8'h51, 8'h6D, 8'h92, "R7");
    idle(4);
    writeCfg(8'h90); runFrame(8'h90, 8'h4B, 8'hD2, "R7");   // ignored in double mode
    idle(4);
    writeCfg(8'h88); runFrame(8'h88, 8'hE7, 8'h18, "R8");
    idle(4);
    writeCfg(8'hA9); runFrame(8'hA9, 8'h2C, 8'hC2, "R8");
    idle(4);
    writeCfg(8'h0A); runFrame(8'h0A, 8'h71, 8'h17, "R8");   // ignored in single mode
    idle(4);
    writeCfg(8'hFF); runFrame(8'hFF, 8'hAA, 8'h55, "R9");
    idle(4);
    writeCfg(8'h00); runFrame(8'h00, 8'h3A, 8'hA3, "R11", 1'b1, 8'h47);
    idle(4);
    runFrame(8'h47, 8'hD9, 8'h9D, "R11");           // new config from mid-frame write
    idle(4);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule